// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives a processor reset line from two sources. The first is an under-voltage flag produced by an external comparator. The second is a watchdog timer that the processor must keep servicing by toggling a service input. Reset is asserted the moment the under-voltage flag goes active. Once the flag clears, reset is held for a programmable stretch. A watchdog that runs out produces a reset pulse of that same stretch. The block then restarts the watchdog, so a processor that has stopped servicing it sees an endless series of reset pulses.

The watchdog period is a programmable base count in clock ticks. A mode input selects either that base period or an extended period of 500 times the base. In extended mode the service input may be marked as undriven. An internal driver then pulses it once, at 94% of the period, which keeps the watchdog from firing. This lets a sleeping processor be woken by a long reset cycle, or be left unsupervised. In normal mode an undriven input gets no such help, and the watchdog still fires. A base count of zero turns the watchdog off.

The reset polarity and the output style (driven both ways, or driven only when asserted) are chosen by parameters.

Top module: `supv_reset_wdog`

## Requirements
- R1: While `uv_i` is 1, reset is asserted in the same cycle and stays asserted.
- R2: After `uv_i` returns to 0, reset stays asserted for exactly `rst_len_i` further clock edges and releases on the last of them. The value 0 behaves like 1.
- R3: A watchdog expiry asserts reset for exactly `rst_len_i` clock edges.
- R4: The watchdog counter restarts from zero on a rising or a falling edge of the service line, or on any change of `wds_i`. Each of these clears the counter on the third clock edge after the input changes (two synchroniser flops, then the edge detector).
- R5: The watchdog counter is held at zero while reset is asserted. It counts from the first edge after release, and it expires on the P-th edge after release or after a clear, where P is the period.
- R6: P is `base_to_i` when `wds_i` is 0, and 500 × `base_to_i` when `wds_i` is 1.
- R7: If the service line never changes, the cycle repeats with no end: P edges of counting, then a reset pulse of `rst_len_i` edges, then P edges again.
- R8: While `wds_i` is 1, `wdi_drv_o` pulses high for one cycle when the counter reaches 470 × `base_to_i`. With `wdi_float_i` at 1, this pulse is the service line, so the watchdog never expires.
- R9: While `wds_i` is 0 and `wdi_float_i` is 1, the service line is static and the watchdog still expires after P edges.
- R10: While `base_to_i` is 0, the watchdog never expires and `wdi_drv_o` stays 0.
- R11: Reset is asserted during `por_n` low. With `uv_i` at 0, it releases `rst_len_i` edges after `por_n` rises.
- R12: Output encoding, by default active-low and driven both ways: `rst_o` is 0 when asserted and 1 when released, and `rst_oe_o` is 1. In the open-drain style, `rst_o` stays at the asserted level and `rst_oe_o` equals the asserted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| uv_i | input | 1 | Under-voltage flag from the external comparator, active high |
| wdi_i | input | 1 | Watchdog service input; either edge services the watchdog |
| wds_i | input | 1 | Mode select: 0 = normal period, 1 = extended period |
| wdi_float_i | input | 1 | 1 when the service input is undriven |
| base_to_i | input | TW | Base watchdog period in clock ticks; 0 turns the watchdog off |
| rst_len_i | input | RW | Reset stretch length in clock ticks |
| rst_o | output | 1 | Reset level |
| rst_oe_o | output | 1 | Reset output enable |
| wdi_drv_o | output | 1 | Internal service drive pulse |

## Verification
The checker relies on `rst_len_i` being held constant for the whole run, since it measures each release window against that value. It also relies on `base_to_i` changing only while reset is asserted or the watchdog is off, so that a count can never jump past its expiry point. The stimulus keeps `rst_len_i` fixed at 5 and changes `base_to_i` only inside reset pulses. Every change of the service and mode inputs is spaced far enough apart that the synchroniser latency of R4 leaves a clean window before the next expected event.

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog #(
  parameter int TW          = 16,
  parameter int RW          = 16,
  parameter int EXT_MULT    = 500,
  parameter int SVC_PCT     = 94,
  parameter bit ACTIVE_HIGH = 1'b0,
  parameter bit OPEN_DRAIN  = 1'b0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          uv_i,
  input  logic          wdi_i,
  input  logic          wds_i,
  input  logic          wdi_float_i,
  input  logic [TW-1:0] base_to_i,
  input  logic [RW-1:0] rst_len_i,
  output logic          rst_o,
  output logic          rst_oe_o,
  output logic          wdi_drv_o
);
  localparam int MW       = $clog2(EXT_MULT + 1);
  localparam int CW       = TW + MW;
  localparam int SVC_MULT = EXT_MULT * SVC_PCT / 100;

  logic          hold_q;
  logic [RW-1:0] rcnt_q;
  logic [CW-1:0] wcnt_q;
  logic [1:0]    wdi_sy, wds_sy;
  logic          wdi_prev, wds_prev;
  logic          drv_q;

  wire rst_act  = uv_i | hold_q;
  wire wdi_line = wdi_float_i ? drv_q : wdi_i;
  wire wdi_s    = wdi_sy[1];
  wire wds_s    = wds_sy[1];
  wire wd_on    = base_to_i != '0;
  wire edge_hit = !rst_act && ((wdi_s ^ wdi_prev) || (wds_s ^ wds_prev));

  wire [CW-1:0] base_w = CW'(base_to_i);
  wire [CW-1:0] period = wds_s ? base_w * CW'(EXT_MULT) : base_w;
  wire [CW-1:0] svc_pt = base_w * CW'(SVC_MULT);
  wire expire = wd_on && !rst_act && !edge_hit && (wcnt_q == period - CW'(1));
  wire rdone  = ({1'b0, rcnt_q} + (RW+1)'(1)) >= {1'b0, rst_len_i};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wdi_sy   <= '0;
      wds_sy   <= '0;
      wdi_prev <= 1'b0;
      wds_prev <= 1'b0;
    end else begin
      wdi_sy   <= {wdi_sy[0], wdi_line};
      wds_sy   <= {wds_sy[0], wds_i};
      wdi_prev <= wdi_s;
      wds_prev <= wds_s;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_q <= 1'b1;
      rcnt_q <= '0;
    end else if (uv_i || expire) begin
      hold_q <= 1'b1;
      rcnt_q <= '0;
    end else if (hold_q) begin
      if (rdone) begin
        hold_q <= 1'b0;
        rcnt_q <= '0;
      end else begin
        rcnt_q <= rcnt_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      wcnt_q <= '0;
    else if (rst_act || !wd_on || edge_hit || expire)
      wcnt_q <= '0;
    else
      wcnt_q <= wcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      drv_q <= 1'b0;
    else
      drv_q <= wds_s && wd_on && !rst_act && (wcnt_q == svc_pt);
  end

  assign wdi_drv_o = drv_q;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign rst_o    = ACTIVE_HIGH;
      assign rst_oe_o = rst_act;
    end else begin : g_pp
      assign rst_o    = ACTIVE_HIGH ? rst_act : ~rst_act;
      assign rst_oe_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/supv_reset_wdog_chk.sv
module supv_reset_wdog_chk #(
  parameter int TW          = 16,
  parameter int RW          = 16,
  parameter int CW          = 25,
  parameter bit ACTIVE_HIGH = 1'b0,
  parameter bit OPEN_DRAIN  = 1'b0
) (
  input logic          clk,
  input logic          por_n,
  input logic          uv_i,
  input logic          rst_o,
  input logic          rst_oe_o,
  input logic          wdi_drv_o,
  input logic [TW-1:0] base_to_i,
  input logic [RW-1:0] rst_len_i,
  input logic [CW-1:0] wcnt_q
);
  wire asserted = OPEN_DRAIN ? rst_oe_o : (rst_o == ACTIVE_HIGH);

  logic [RW:0] acnt;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      acnt <= '0;
    else if (asserted && !uv_i)
      acnt <= (acnt == '1) ? acnt : acnt + (RW+1)'(1);
    else
      acnt <= '0;
  end

  assert_uv_holds_R1: assert property (@(posedge clk) disable iff (!por_n)
    uv_i |-> asserted);

  assert_no_early_release_R2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(asserted) |-> $past(!uv_i));

  assert_release_width_R3: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(asserted) && rst_len_i != '0) |-> (acnt == {1'b0, rst_len_i}));

  assert_wdog_held_R5: assert property (@(posedge clk) disable iff (!por_n)
    asserted |=> (wcnt_q == '0));

  assert_drv_single_R8: assert property (@(posedge clk) disable iff (!por_n)
    wdi_drv_o |=> !wdi_drv_o);

  assert_wdog_off_R10: assert property (@(posedge clk) disable iff (!por_n)
    (base_to_i == '0) |=> (wcnt_q == '0 && !wdi_drv_o));
endmodule

bind supv_reset_wdog supv_reset_wdog_chk #(
  .TW(TW), .RW(RW), .CW(CW), .ACTIVE_HIGH(ACTIVE_HIGH), .OPEN_DRAIN(OPEN_DRAIN)
) u_chk (
  .clk(clk), .por_n(por_n), .uv_i(uv_i), .rst_o(rst_o), .rst_oe_o(rst_oe_o),
  .wdi_drv_o(wdi_drv_o), .base_to_i(base_to_i), .rst_len_i(rst_len_i),
  .wcnt_q(wcnt_q)
);

// File: tb/supv_reset_wdog_bench.sv
`timescale 1ns/1ps
module supv_reset_wdog_bench;
  localparam int L = 5;

  logic clk = 1'b0;
  logic por_n, uv, wdi, wds, fl;
  logic [15:0] base, len;
  logic rst_o, rst_oe_o, wdi_drv_o;

  always #10 clk = ~clk;

  supv_reset_wdog u_supv_reset_wdog (
    .clk(clk), .por_n(por_n), .uv_i(uv), .wdi_i(wdi), .wds_i(wds),
    .wdi_float_i(fl), .base_to_i(base), .rst_len_i(len),
    .rst_o(rst_o), .rst_oe_o(rst_oe_o), .wdi_drv_o(wdi_drv_o)
  );

  typedef struct {
    int    when;
    bit    act;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int nvec = 0;
  int nbad = 0;
  int drv_n = 0;
  bit drv_en = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_rst(int d, bit act, string tag);
    exp_t e;
    e.when = cyc + d;
    e.act  = act;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (drv_en && wdi_drv_o) drv_n++;
    while (q.size() > 0 && q[0].when <= cyc) begin
      e = q.pop_front();
      check(e.when == cyc, {e.tag, " sample slot"}, cyc, e.when);
      check(rst_o == !e.act, e.tag, int'(rst_o), int'(!e.act));
      check(rst_oe_o == 1'b1, "R12 enable", int'(rst_oe_o), 1);
    end
  end

  initial begin
    por_n = 1'b0; uv = 1'b0; wdi = 1'b0; wds = 1'b0; fl = 1'b0;
    base = 16'd0; len = 16'(L);
    tick(3);
    expect_rst(1, 1'b1, "R11 power-on");
    tick(2);
    por_n = 1'b1;
    expect_rst(L-1, 1'b1, "R11 held");
    expect_rst(L,   1'b0, "R11 release");
    tick(L+1);

    expect_rst(3000, 1'b0, "R10 disabled");
    tick(3000);

    uv = 1'b1;
    expect_rst(1,  1'b1, "R1 immediate");
    expect_rst(20, 1'b1, "R1 held");
    tick(20);

    uv = 1'b0; base = 16'd4;
    expect_rst(L-1,   1'b1, "R2 held");
    expect_rst(L,     1'b0, "R2 release");
    expect_rst(L+3,   1'b0, "R5 counting");
    expect_rst(L+4,   1'b1, "R5 R6 expiry");
    expect_rst(2*L+3, 1'b1, "R3 pulse");
    expect_rst(2*L+4, 1'b0, "R3 end");
    expect_rst(2*L+7, 1'b0, "R7 counting");
    expect_rst(2*L+8, 1'b1, "R7 repeat");
    tick(2*L+8);
    base = 16'd8;
    tick(L);

    for (int i = 0; i < 10; i++) begin
      wdi = ~wdi;
      expect_rst(2, 1'b0, "R4 serviced");
      if (i < 9) tick(4);
    end
    expect_rst(10, 1'b0, "R4 falling edge");
    expect_rst(11, 1'b1, "R4 timeout after last edge");
    tick(11+L);
    tick(1);

    wds = 1'b1;
    expect_rst(4002, 1'b0, "R6 extended");
    expect_rst(4003, 1'b1, "R6 extended expiry");
    tick(4003+L);
    tick(3000);

    wds = 1'b0;
    expect_rst(10, 1'b0, "R4 mode clear");
    expect_rst(11, 1'b1, "R4 mode clear expiry");
    tick(11);

    wds = 1'b1; fl = 1'b1; drv_en = 1'b1; drv_n = 0;
    tick(L);
    expect_rst(4000,  1'b0, "R8 self-serviced");
    expect_rst(8000,  1'b0, "R8 self-serviced");
    expect_rst(12000, 1'b0, "R8 self-serviced");
    tick(12000);
    check(drv_n == 3, "R8 drive pulses", drv_n, 3);

    drv_en = 1'b0;
    wds = 1'b0;
    expect_rst(10, 1'b0, "R9 normal undriven");
    expect_rst(11, 1'b1, "R9 normal undriven expiry");
    tick(12);

    check(q.size() == 0, "R12 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule